// File: doc/BRIEF.md
# Machine-Cycle Sequencer for a Reduced 8-bit Instruction Subset

This block is the control heart of a small 8-bit processor core. It reads opcodes, decides which machine cycles each instruction needs, and for every machine cycle hands a request (a cycle kind and a 16-bit address) to a separate bus cycle generator. It then waits for that generator to report completion and takes the byte it returns. The sequencer holds the program counter, an accumulator and three 16-bit register pairs, and it executes a handful of instruction classes:
- register-to-register moves
- immediate loads
- input from an 8-bit port
- accumulator load from a direct address
- flag-free 16-bit pair increments

Each request kind implies a T-state count that the generator runs:
- opcode fetch: 4 T-states
- memory read: 3 T-states
- I/O read: 3 T-states
- fetch stretch: 2 T-states, with no bus transfer

A pair increment is therefore one opcode-fetch machine cycle stretched to 6 T-states. The sequencer keeps no flags, so a pair increment cannot disturb any flag. An opcode outside the supported set behaves as a one-cycle no-operation and raises a sticky status bit.

Top module: `mcycle_sequencer`

## Requirements
- R1: While reset is low and in the first cycle after it, `req_valid` is 0. The program counter is 0000h, all registers are 0 and `illegal_o` is 0. The first request is an opcode fetch at 0000h.
- R2: Request encodings on `req_kind` are: 0 = opcode fetch, 1 = memory read, 2 = I/O read, 3 = fetch stretch. Once `req_valid` is raised, `req_kind` and `req_addr` stay unchanged, and `req_valid` stays 1, until a clock edge where `bus_done` is 1. A transfer completes only on such an edge.
- R3: Each opcode and operand byte is read at the program counter, and the program counter rises by one after each such byte.
- R4: Opcodes 01dddsss copy register sss into register ddd in a single opcode fetch, using these register codes:

  | Code | Register |
  |------|----------|
  | 0 | B |
  | 1 | C |
  | 2 | D |
  | 3 | E |
  | 4 | H |
  | 5 | L |
  | 7 | A |

- R5: Opcodes 00pp0011 increment a register pair (pp 0 = BC, 1 = DE, 2 = HL). The instruction is an opcode fetch followed by a fetch stretch, whose address is the byte after the opcode. The increment carries across all 16 bits (1FFFh to 2000h, FFFFh to 0000h) and changes nothing else.
- R6: Opcodes 00ddd110 load register ddd from a memory read of the following byte.
- R7: Opcode DBh runs an opcode fetch and a memory read of the port byte p. It then runs an I/O read at address {p,p}, and the data from that read goes to A.
- R8: Opcode 3Ah runs an opcode fetch and memory reads of a low byte and then a high byte. It then runs a memory read at {high,low}, and the data from that read goes to A.
- R9: Every other opcode, including any use of register code 6, opcode 33h and opcode 76h, is a single opcode fetch that changes no register. It sets `illegal_o`, which then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_done | input | 1 | Bus cycle generator reports the current request complete |
| bus_rdata | input | 8 | Byte returned with `bus_done` |
| req_valid | output | 1 | A machine-cycle request is presented |
| req_kind | output | 2 | Kind of the requested cycle (encoding in R2) |
| req_addr | output | 16 | Address of the requested cycle |
| pc_o | output | 16 | Program counter |
| acc_o | output | 8 | Accumulator |
| bc_o | output | 16 | BC pair, B in the high byte |
| de_o | output | 16 | DE pair, D in the high byte |
| hl_o | output | 16 | HL pair, H in the high byte |
| illegal_o | output | 1 | Sticky unsupported-opcode status |

## Verification
The hardest situation to reach is a request that is held across several clocks while the generator delays completion, in the middle of a multi-cycle instruction. A second hard case is a carry rippling through the whole pair. The bench models the generator with a varying number of wait clocks per request, so requests are held while instructions are partly done. A directed program loads FFh into both halves of pairs before incrementing them. The program then runs on into a long computed byte pattern that covers every opcode value, so that every supported class and many unsupported codes meet arbitrary register contents.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    localparam int unsigned DW   = 8;
    localparam int unsigned AW   = 2 * DW;
    localparam int unsigned NREG = 8;
    localparam int unsigned RSW  = $clog2(NREG);

    localparam logic [RSW-1:0] REG_A   = 3'd7;
    localparam logic [RSW-1:0] REG_MEM = 3'd6;

    localparam logic [DW-1:0] OPC_PORT_IN  = 8'hDB;
    localparam logic [DW-1:0] OPC_LOAD_DIR = 8'h3A;

    typedef enum logic [1:0] {
        BK_FETCH   = 2'd0,
        BK_MEMRD   = 2'd1,
        BK_IORD    = 2'd2,
        BK_STRETCH = 2'd3
    } bus_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STRETCH,
        ST_OPND_LO,
        ST_OPND_HI,
        ST_PORT_RD,
        ST_DIRECT_RD
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_MOVE,
        OP_PAIR_INC,
        OP_LOAD_IMM,
        OP_PORT_IN,
        OP_LOAD_DIR,
        OP_BAD
    } op_class_e;

    typedef struct packed {
        seq_state_e     st;
        logic [AW-1:0]  pc;
        logic [DW-1:0]  opcode;
        logic [DW-1:0]  lo;
        logic [DW-1:0]  hi;
        logic           illegal;
    } seq_regs_t;

endpackage

// File: rtl/mcs_decode.sv
module mcs_decode
    import mcs_pkg::*;
(
    input  logic [DW-1:0]  op,
    output op_class_e      cls,
    output logic [RSW-1:0] dst,
    output logic [RSW-1:0] src,
    output logic [1:0]     pair
);

    always_comb begin
        cls  = OP_BAD;
        dst  = op[5:3];
        src  = op[2:0];
        pair = op[5:4];
        if (op[7:6] == 2'b01) begin
            if (op[5:3] != REG_MEM && op[2:0] != REG_MEM) begin
                cls = OP_MOVE;
            end
        end else if (op[7:6] == 2'b00 && op[3:0] == 4'b0011) begin
            if (op[5:4] != 2'b11) begin
                cls = OP_PAIR_INC;
            end
        end else if (op[7:6] == 2'b00 && op[2:0] == 3'b110) begin
            if (op[5:3] != REG_MEM) begin
                cls = OP_LOAD_IMM;
            end
        end else if (op == OPC_PORT_IN) begin
            cls = OP_PORT_IN;
        end else if (op == OPC_LOAD_DIR) begin
            cls = OP_LOAD_DIR;
        end
    end

endmodule

// File: rtl/mcs_regfile.sv
module mcs_regfile
    import mcs_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr8_en,
    input  logic [RSW-1:0] wr8_sel,
    input  logic [DW-1:0]  wr8_data,
    input  logic           wr16_en,
    input  logic [1:0]     wr16_sel,
    input  logic [AW-1:0]  wr16_data,
    input  logic [RSW-1:0] rd8_sel,
    output logic [DW-1:0]  rd8_data,
    input  logic [1:0]     rd16_sel,
    output logic [AW-1:0]  rd16_data,
    output logic [DW-1:0]  acc,
    output logic [AW-1:0]  bc,
    output logic [AW-1:0]  de,
    output logic [AW-1:0]  hl
);

    localparam int unsigned NPAIR = 3;

    logic [DW-1:0] r_q [NREG];
    logic [DW-1:0] r_d [NREG];
    logic [AW-1:0] pair_view [NPAIR];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            r_d[i] = r_q[i];
        end
        if (wr16_en) begin
            r_d[{wr16_sel, 1'b0}] = wr16_data[AW-1:DW];
            r_d[{wr16_sel, 1'b1}] = wr16_data[DW-1:0];
        end
        if (wr8_en) begin
            r_d[wr8_sel] = wr8_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n) begin
                r_q[i] <= '0;
            end else begin
                r_q[i] <= r_d[i];
            end
        end
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pair_view[p] = {r_q[2*p], r_q[2*p+1]};
    end

    assign rd8_data  = r_q[rd8_sel];
    assign rd16_data = (rd16_sel < 2'(NPAIR)) ? pair_view[rd16_sel] : '0;
    assign acc       = r_q[REG_A];
    assign bc        = pair_view[0];
    assign de        = pair_view[1];
    assign hl        = pair_view[2];

endmodule

// File: rtl/mcycle_sequencer.sv
module mcycle_sequencer
    import mcs_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0000
)
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_done,
    input  logic [7:0]  bus_rdata,
    output logic        req_valid,
    output logic [1:0]  req_kind,
    output logic [15:0] req_addr,
    output logic [15:0] pc_o,
    output logic [7:0]  acc_o,
    output logic [15:0] bc_o,
    output logic [15:0] de_o,
    output logic [15:0] hl_o,
    output logic        illegal_o
);

    seq_regs_t s_q, s_d;

    logic [DW-1:0]  dec_op;
    op_class_e      dec_cls;
    logic [RSW-1:0] dec_dst, dec_src;
    logic [1:0]     dec_pair;

    logic           wr8_en, wr16_en;
    logic [RSW-1:0] wr8_sel;
    logic [DW-1:0]  wr8_data, rd8_data;
    logic [AW-1:0]  wr16_data, rd16_data;
    logic           xfer;
    bus_kind_e      kind;

    assign dec_op = (s_q.st == ST_FETCH) ? bus_rdata : s_q.opcode;

    mcs_decode u_decode (
        .op   (dec_op),
        .cls  (dec_cls),
        .dst  (dec_dst),
        .src  (dec_src),
        .pair (dec_pair)
    );

    mcs_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr8_en    (wr8_en),
        .wr8_sel   (wr8_sel),
        .wr8_data  (wr8_data),
        .wr16_en   (wr16_en),
        .wr16_sel  (dec_pair),
        .wr16_data (wr16_data),
        .rd8_sel   (dec_src),
        .rd8_data  (rd8_data),
        .rd16_sel  (dec_pair),
        .rd16_data (rd16_data),
        .acc       (acc_o),
        .bc        (bc_o),
        .de        (de_o),
        .hl        (hl_o)
    );

    // Request presented by the current state
    always_comb begin
        kind     = BK_FETCH;
        req_addr = s_q.pc;
        unique case (s_q.st)
            ST_STRETCH:   kind = BK_STRETCH;
            ST_OPND_LO,
            ST_OPND_HI:   kind = BK_MEMRD;
            ST_PORT_RD: begin
                kind     = BK_IORD;
                req_addr = {s_q.lo, s_q.lo};
            end
            ST_DIRECT_RD: begin
                kind     = BK_MEMRD;
                req_addr = {s_q.hi, s_q.lo};
            end
            default:      kind = BK_FETCH;
        endcase
    end

    assign req_valid = (s_q.st != ST_IDLE);
    assign req_kind  = kind;
    assign xfer      = req_valid && bus_done;

    // Next-state computation
    always_comb begin
        s_d       = s_q;
        wr8_en    = 1'b0;
        wr8_sel   = dec_dst;
        wr8_data  = bus_rdata;
        wr16_en   = 1'b0;
        wr16_data = rd16_data + AW'(1);

        unique case (s_q.st)
            ST_IDLE: s_d.st = ST_FETCH;

            ST_FETCH: if (xfer) begin
                s_d.pc     = s_q.pc + AW'(1);
                s_d.opcode = bus_rdata;
                unique case (dec_cls)
                    OP_MOVE: begin
                        wr8_en   = 1'b1;
                        wr8_data = rd8_data;
                    end
                    OP_PAIR_INC: s_d.st = ST_STRETCH;
                    OP_LOAD_IMM,
                    OP_PORT_IN,
                    OP_LOAD_DIR: s_d.st = ST_OPND_LO;
                    default:     s_d.illegal = 1'b1;
                endcase
            end

            ST_STRETCH: if (xfer) begin
                wr16_en = 1'b1;
                s_d.st  = ST_FETCH;
            end

            ST_OPND_LO: if (xfer) begin
                s_d.pc = s_q.pc + AW'(1);
                s_d.lo = bus_rdata;
                unique case (dec_cls)
                    OP_PORT_IN:  s_d.st = ST_PORT_RD;
                    OP_LOAD_DIR: s_d.st = ST_OPND_HI;
                    default: begin
                        wr8_en = 1'b1;
                        s_d.st = ST_FETCH;
                    end
                endcase
            end

            ST_OPND_HI: if (xfer) begin
                s_d.pc = s_q.pc + AW'(1);
                s_d.hi = bus_rdata;
                s_d.st = ST_DIRECT_RD;
            end

            ST_PORT_RD,
            ST_DIRECT_RD: if (xfer) begin
                wr8_en  = 1'b1;
                wr8_sel = REG_A;
                s_d.st  = ST_FETCH;
            end

            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.st      <= ST_IDLE;
            s_q.pc      <= RESET_PC;
        end else begin
            s_q <= s_d;
        end
    end

    assign pc_o      = s_q.pc;
    assign illegal_o = s_q.illegal;

endmodule

// File: rtl/mcs_checker.sv
module mcs_checker
    import mcs_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_done,
    input logic [7:0]  bus_rdata,
    input logic        req_valid,
    input logic [1:0]  req_kind,
    input logic [15:0] req_addr,
    input logic [15:0] pc_o,
    input logic        illegal_o
);

    logic fetch_done;
    assign fetch_done = req_valid && bus_done && (req_kind == BK_FETCH);

    // R2: a pending request is held unchanged until completion
    a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !bus_done) |=>
            (req_valid && $stable(req_kind) && $stable(req_addr)));

    // R3: the program counter steps by one after each opcode byte
    a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> (pc_o == $past(pc_o) + 16'd1));

    // R5: pair increments stretch the fetch by a no-transfer cycle
    a_r5_stretch_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_done && (bus_rdata == 8'h03 || bus_rdata == 8'h13 || bus_rdata == 8'h23))
            |=> (req_valid && req_kind == BK_STRETCH));

    // R7: port address appears on both halves of the request address
    a_r7_port_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == BK_IORD) |-> (req_addr[15:8] == req_addr[7:0]));

    // R8: direct load reads its low address byte right after the opcode
    a_r8_direct_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_done && bus_rdata == 8'h3A)
            |=> (req_valid && req_kind == BK_MEMRD && req_addr == $past(req_addr) + 16'd1));

    // R9: the illegal-opcode status never clears without reset
    a_r9_sticky_status: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> illegal_o);

endmodule

bind mcycle_sequencer mcs_checker u_mcs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_done  (bus_done),
    .bus_rdata (bus_rdata),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .pc_o      (pc_o),
    .illegal_o (illegal_o)
);

// File: tb/mcycle_sequencer_bench.sv
module mcycle_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_done;
    logic [7:0]  bus_rdata;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [15:0] req_addr;
    logic [15:0] pc_o, bc_o, de_o, hl_o;
    logic [7:0]  acc_o;
    logic        illegal_o;

    always #10 clk = ~clk;

    mcycle_sequencer u_mcycle_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_done  (bus_done),
        .bus_rdata (bus_rdata),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .pc_o      (pc_o),
        .acc_o     (acc_o),
        .bc_o      (bc_o),
        .de_o      (de_o),
        .hl_o      (hl_o),
        .illegal_o (illegal_o)
    );

    localparam int PROG_LEN = 26;
    logic [7:0] prog [PROG_LEN] = '{
        8'h06, 8'h1F, 8'h0E, 8'hFF, 8'h03, 8'h26, 8'hFF, 8'h2E, 8'hFF, 8'h23,
        8'h3A, 8'h34, 8'h12, 8'hDB, 8'h7E, 8'h47, 8'h13, 8'h3E, 8'h5A, 8'h4F,
        8'h76, 8'h33, 8'h00, 8'h1E, 8'h80, 8'h7B };

    int checks = 0;
    int failures = 0;

    function automatic logic [7:0] memf(input logic [15:0] a);
        if (a < 16'(PROG_LEN)) return prog[a];
        return 8'(32'(a[7:0]) * 29 + 32'(a[15:8]) * 7 + 3);
    endfunction

    function automatic logic [7:0] iof(input logic [7:0] p);
        return p ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model: architectural state and expected request queue
    logic [7:0]  mr [8];
    logic [7:0]  nr [8];
    logic [15:0] mpc, npc;
    logic        mill, nill;
    logic [1:0]  qk [$];
    logic [15:0] qa [$];
    string       cur_tag = "R1";
    string       nxt_tag;
    int          ninstr = 0;

    task automatic push(input logic [1:0] k, input logic [15:0] a);
        qk.push_back(k);
        qa.push_back(a);
    endtask

    task automatic plan();
        logic [7:0] op, lo, hi;
        logic [15:0] pv;
        op = memf(mpc);
        for (int i = 0; i < 8; i++) nr[i] = mr[i];
        npc  = mpc + 16'd1;
        nill = mill;
        push(2'd0, mpc);
        if (op[7:6] == 2'b01 && op[5:3] != 3'd6 && op[2:0] != 3'd6) begin
            nr[op[5:3]] = mr[op[2:0]];
            nxt_tag = "R4";
        end else if (op[7:6] == 2'b00 && op[3:0] == 4'h3 && op[5:4] != 2'b11) begin
            pv = {mr[{op[5:4], 1'b0}], mr[{op[5:4], 1'b1}]} + 16'd1;
            nr[{op[5:4], 1'b0}] = pv[15:8];
            nr[{op[5:4], 1'b1}] = pv[7:0];
            push(2'd3, npc);
            nxt_tag = "R5";
        end else if (op[7:6] == 2'b00 && op[2:0] == 3'b110 && op[5:3] != 3'd6) begin
            push(2'd1, npc);
            nr[op[5:3]] = memf(npc);
            npc = npc + 16'd1;
            nxt_tag = "R6";
        end else if (op == 8'hDB) begin
            lo = memf(npc);
            push(2'd1, npc);
            npc = npc + 16'd1;
            push(2'd2, {lo, lo});
            nr[7] = iof(lo);
            nxt_tag = "R7";
        end else if (op == 8'h3A) begin
            lo = memf(npc);
            hi = memf(npc + 16'd1);
            push(2'd1, npc);
            push(2'd1, npc + 16'd1);
            npc = npc + 16'd2;
            push(2'd1, {hi, lo});
            nr[7] = memf({hi, lo});
            nxt_tag = "R8";
        end else begin
            nill = 1'b1;
            nxt_tag = "R9";
        end
    endtask

    task automatic directed_checks();
        case (mpc)
            16'h0005: chk(bc_o == 16'h2000, "R5", "BC carry 1FFF->2000", 32'(bc_o), 32'h2000);
            16'h000A: chk(hl_o == 16'h0000, "R5", "HL wrap FFFF->0000", 32'(hl_o), 32'h0);
            16'h000D: chk(acc_o == memf(16'h1234), "R8", "direct load", 32'(acc_o), 32'(memf(16'h1234)));
            16'h000F: chk(acc_o == iof(8'h7E), "R7", "port input", 32'(acc_o), 32'(iof(8'h7E)));
            16'h0010: chk(bc_o[15:8] == iof(8'h7E), "R4", "move A to B", 32'(bc_o[15:8]), 32'(iof(8'h7E)));
            16'h0011: chk(de_o == 16'h0001, "R5", "DE increment", 32'(de_o), 32'h1);
            16'h0013: chk(acc_o == 8'h5A, "R6", "immediate to A", 32'(acc_o), 32'h5A);
            16'h0014: begin
                chk(bc_o[7:0] == 8'h5A, "R4", "move A to C", 32'(bc_o[7:0]), 32'h5A);
                chk(illegal_o == 1'b0, "R9", "status clear before bad opcode", 32'(illegal_o), 32'h0);
            end
            16'h0015: chk(illegal_o == 1'b1, "R9", "status set by 76h", 32'(illegal_o), 32'h1);
            16'h001A: begin
                chk(acc_o == 8'h80, "R4", "move E to A", 32'(acc_o), 32'h80);
                chk(illegal_o == 1'b1, "R9", "status sticky", 32'(illegal_o), 32'h1);
            end
            default: ;
        endcase
    endtask

    initial begin
        int cycles = 0;
        int stall = 0;
        int wait_cnt = 1;
        bit first = 1'b1;
        bit pending = 1'b0;
        logic [1:0] pk;
        logic [15:0] pa;
        bit finished = 1'b0;

        rst_n     = 1'b0;
        bus_done  = 1'b0;
        bus_rdata = 8'h00;
        for (int i = 0; i < 8; i++) mr[i] = 8'h00;
        mpc  = 16'h0000;
        mill = 1'b0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(req_valid == 1'b0, "R1", "valid in reset", 32'(req_valid), 32'h0);
        rst_n = 1'b1;
        chk(pc_o == 16'h0000, "R1", "reset pc", 32'(pc_o), 32'h0);
        chk(acc_o == 8'h00 && bc_o == 16'h0 && de_o == 16'h0 && hl_o == 16'h0,
            "R1", "reset registers", 32'(acc_o), 32'h0);
        chk(illegal_o == 1'b0, "R1", "reset status", 32'(illegal_o), 32'h0);

        while (!finished) begin
            @(negedge clk);
            cycles++;
            stall++;

            // architectural state against the model, every clock
            chk(acc_o == mr[7], cur_tag, "A", 32'(acc_o), 32'(mr[7]));
            chk(bc_o == {mr[0], mr[1]}, cur_tag, "BC", 32'(bc_o), 32'({mr[0], mr[1]}));
            chk(de_o == {mr[2], mr[3]}, cur_tag, "DE", 32'(de_o), 32'({mr[2], mr[3]}));
            chk(hl_o == {mr[4], mr[5]}, cur_tag, "HL", 32'(hl_o), 32'({mr[4], mr[5]}));
            chk(illegal_o == mill, "R9", "status", 32'(illegal_o), 32'(mill));

            if (pending) begin
                chk(req_valid && req_kind == pk && req_addr == pa, "R2", "held request",
                    32'({req_valid, req_kind, req_addr}), 32'({1'b1, pk, pa}));
            end

            if (qk.size() == 0) begin
                chk(pc_o == mpc, "R3", "pc at instruction start", 32'(pc_o), 32'(mpc));
                directed_checks();
                plan();
            end

            pending = 1'b0;
            if (req_valid) begin
                if (wait_cnt == 0) begin
                    bus_done  = 1'b1;
                    bus_rdata = (req_kind == 2'd2) ? iof(req_addr[7:0]) :
                                (req_kind == 2'd3) ? 8'h00 : memf(req_addr);
                    if (first) begin
                        chk(req_kind == 2'd0 && req_addr == 16'h0000, "R1", "first request",
                            32'({req_kind, req_addr}), 32'h0);
                        first = 1'b0;
                    end
                    chk(req_kind == qk[0], nxt_tag, "request kind", 32'(req_kind), 32'(qk[0]));
                    chk(req_addr == qa[0], (req_kind == 2'd0 || qa[0] == mpc) ? "R3" : nxt_tag,
                        "request address", 32'(req_addr), 32'(qa[0]));
                    void'(qk.pop_front());
                    void'(qa.pop_front());
                    stall = 0;
                    if (qk.size() == 0) begin
                        for (int i = 0; i < 8; i++) mr[i] = nr[i];
                        mpc     = npc;
                        mill    = nill;
                        cur_tag = nxt_tag;
                        ninstr++;
                    end
                    wait_cnt = $urandom_range(0, 2);
                end else begin
                    bus_done = 1'b0;
                    wait_cnt--;
                    pending  = 1'b1;
                    pk       = req_kind;
                    pa       = req_addr;
                end
            end else begin
                bus_done = 1'b0;
            end

            if (ninstr >= 400) finished = 1'b1;
            if (cycles > 150000 || stall > 50) begin
                chk(1'b0, "R2", "watchdog expired", 32'(cycles), 32'(0));
                finished = 1'b1;
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule